// File: doc/BRIEF.md
# Multi-Queue Operand Exchange Array

This block is a central store shared by several processor cores, holding many independent first-in first-out queues. A producing thread writes a 64-bit operand into a queue and a consuming thread reads it out. The two threads of a communicating pair agree on a queue number, and that number selects the same queue for both directions. Cores reach the store through a small number of access ports. Each port can carry one request per cycle, and several cores can present requests to one port at the same time.

A request is either a produce (queue number plus operand) or a consume (queue number). A request that can be served finishes in the cycle it is presented. A consume gets the oldest operand of its queue back in that same cycle. A request that cannot be served is not dropped. The block raises a stall for it, and the core keeps presenting it until it finishes. A produce to a full queue stalls, and so does a consume from an empty queue. When several cores use one port, the most upstream core (lowest client index) is served and the rest stall.

When two ports address the same queue with the same kind of request in one cycle, the lower-numbered port wins and the other stalls. A produce and a consume on the same queue in the same cycle can both finish.

Top module: `sa_sync_array`

## Requirements
- R1: A produce request that finishes enqueues its 64-bit operand and raises its done flag in the same cycle it is presented, with its stall flag low.
- R2: Within one queue, consumes return operands in the order in which they were produced. The operand appears on the requester's response data in the cycle its done flag is high.
- R3: Each queue holds 32 operands. Thirty-two produces to an empty queue all finish, and a further produce stalls.
- R4: A produce to a full queue raises stall and does not finish. If a consume to that queue finishes in some cycle, the held produce finishes in the following cycle.
- R5: A consume from an empty queue raises stall and does not finish. This holds even when a produce to the same queue finishes in that cycle; the operand can be consumed from the next cycle on.
- R6: The 4-bit queue number (values 0 to 15) selects one of 16 independent queues. Traffic on one queue never changes the contents or order of another.
- R7: On one port, when several clients present requests, only the lowest-indexed client is served. Every other client on that port stalls in that cycle.
- R8: When two or more ports present the same kind of request (produce or consume) to the same queue in one cycle, only the lowest-numbered port can finish. The others stall.
- R9: A produce and a consume to the same non-empty queue in the same cycle both finish, and the queue's occupancy is unchanged afterwards.
- R10: While reset is asserted, no done or stall flag is raised. After reset every queue is empty.
- R11: The four ports serve requests to different queues in the same cycle, independently of one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid_i | input | 8 | Request present, one bit per client; client c of port p is bit p*2+c |
| req_produce_i | input | 8 | 1 = produce, 0 = consume, per client |
| req_qid_i | input | 32 | 4-bit queue number per client, client i in bits [4i+3:4i] |
| req_data_i | input | 512 | 64-bit operand per client for produces, client i in bits [64i+63:64i] |
| req_done_o | output | 8 | Request finished this cycle, per client |
| req_stall_o | output | 8 | Request present but not finished this cycle, per client |
| rsp_data_o | output | 512 | Operand returned for a finishing consume, per client |

## Verification
The hardest situations to reach are those where a queue boundary meets a same-cycle collision. One case is a produce held on a full queue that is released by a consume arriving on another port. Another is a consume on an empty queue that arrives together with the produce that would fill it. Directed phases fill one queue to exactly 32 entries and hold the next produce for several cycles before a consume is added. They also pair an empty-queue consume with a produce in the same cycle. After that, a long random phase confines all traffic to four queues, so collisions at both full and empty happen often. A behavioural model of per-queue contents predicts every done, stall and returned operand on each clock.

// File: rtl/sa_pkg.sv
package sa_pkg;
  // request kind carried on req_produce_i
  typedef enum logic {
    SA_OP_CONSUME = 1'b0,
    SA_OP_PRODUCE = 1'b1
  } sa_op_e;

  localparam int unsigned SA_DEF_PORTS   = 4;
  localparam int unsigned SA_DEF_CLIENTS = 2;
  localparam int unsigned SA_DEF_QUEUES  = 16;
  localparam int unsigned SA_DEF_DEPTH   = 32;
  localparam int unsigned SA_DEF_DATA_W  = 64;
endpackage

// File: rtl/sa_port_arb.sv
// Fixed-priority selector: lowest index (most upstream client) wins.
module sa_port_arb #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o
);
  logic [N-1:0] taken;

  always_comb begin
    grant_o = '0;
    taken   = '0;
    for (int i = 0; i < N; i++) begin
      if (i > 0) taken[i] = taken[i-1] | req_i[i-1];
      grant_o[i] = req_i[i] & ~taken[i];
    end
  end

  // R7: at most one winner per port
  p_one_grant_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  // R7: a grant only goes to a requesting client
  p_grant_needs_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~req_i) == '0);
  // R7: the most upstream client is never passed over
  p_upstream_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[0] |-> grant_o[0]);
endmodule

// File: rtl/sa_queue_bank.sv
// Storage for all logical queues plus per-queue occupancy tracking.
module sa_queue_bank #(
  parameter int unsigned NPORT  = 4,
  parameter int unsigned NQ     = 16,
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DW     = 64,
  parameter int unsigned QW     = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pv_i     [NPORT],
  input  logic          ppush_i  [NPORT],
  input  logic [QW-1:0] pqid_i   [NPORT],
  input  logic [DW-1:0] pdata_i  [NPORT],
  output logic          pacc_o   [NPORT],
  output logic [DW-1:0] prdata_o [NPORT]
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned SW = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic [DW-1:0] mem    [NQ][DEPTH];
  logic [PW-1:0] head_q [NQ];
  logic [PW-1:0] tail_q [NQ];
  logic [CW-1:0] cnt_q  [NQ];
  logic [PW-1:0] head_d [NQ];
  logic [PW-1:0] tail_d [NQ];
  logic [CW-1:0] cnt_d  [NQ];

  logic [NQ-1:0] push_en;
  logic [NQ-1:0] pop_en;
  logic [SW-1:0] wsel   [NQ];
  logic [NPORT-1:0] shadowed;

  // a port is shadowed when a lower port makes the same kind of request to the same queue
  always_comb begin
    shadowed = '0;
    for (int p = 0; p < NPORT; p++) begin
      for (int k = 0; k < p; k++) begin
        if (pv_i[k] && pv_i[p] && (ppush_i[k] == ppush_i[p]) && (pqid_i[k] == pqid_i[p]))
          shadowed[p] = 1'b1;
      end
    end
  end

  always_comb begin
    push_en = '0;
    pop_en  = '0;
    for (int q = 0; q < NQ; q++) wsel[q] = '0;
    for (int p = 0; p < NPORT; p++) begin
      pacc_o[p] = 1'b0;
      if (pv_i[p] && !shadowed[p]) begin
        if (ppush_i[p]) begin
          if (cnt_q[pqid_i[p]] != CW'(DEPTH)) begin
            pacc_o[p]          = 1'b1;
            push_en[pqid_i[p]] = 1'b1;
            wsel[pqid_i[p]]    = SW'(p);
          end
        end else if (cnt_q[pqid_i[p]] != '0) begin
          pacc_o[p]         = 1'b1;
          pop_en[pqid_i[p]] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++)
      prdata_o[p] = mem[pqid_i[p]][head_q[pqid_i[p]]];
  end

  // next-state for pointers and counts
  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      head_d[q] = head_q[q];
      tail_d[q] = tail_q[q];
      cnt_d[q]  = cnt_q[q];
      if (pop_en[q])
        head_d[q] = (head_q[q] == PW'(DEPTH - 1)) ? '0 : head_q[q] + 1'b1;
      if (push_en[q])
        tail_d[q] = (tail_q[q] == PW'(DEPTH - 1)) ? '0 : tail_q[q] + 1'b1;
      if (push_en[q] && !pop_en[q])
        cnt_d[q] = cnt_q[q] + 1'b1;
      else if (pop_en[q] && !push_en[q])
        cnt_d[q] = cnt_q[q] - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int q = 0; q < NQ; q++) begin
        head_q[q] <= '0;
        tail_q[q] <= '0;
        cnt_q[q]  <= '0;
      end
    end else begin
      for (int q = 0; q < NQ; q++) begin
        if (push_en[q] || pop_en[q]) begin
          head_q[q] <= head_d[q];
          tail_q[q] <= tail_d[q];
          cnt_q[q]  <= cnt_d[q];
        end
      end
    end
  end

  for (genvar gq = 0; gq < NQ; gq++) begin : g_store
    always_ff @(posedge clk_i) begin
      if (push_en[gq]) mem[gq][tail_q[gq]] <= pdata_i[wsel[gq]];
    end

    // R3: occupancy never exceeds the queue size
    p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q[gq] <= CW'(DEPTH));
    // R5: nothing is removed from an empty queue
    p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_en[gq] |-> (cnt_q[gq] != '0));
    // R9: simultaneous enqueue and dequeue keep the occupancy
    p_count_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_en[gq] && pop_en[gq]) |=> (cnt_q[gq] == $past(cnt_q[gq])));
  end
endmodule

// File: rtl/sa_sync_array.sv
module sa_sync_array
  import sa_pkg::*;
#(
  parameter int unsigned NPORT   = SA_DEF_PORTS,
  parameter int unsigned NCLIENT = SA_DEF_CLIENTS,
  parameter int unsigned NQ      = SA_DEF_QUEUES,
  parameter int unsigned DEPTH   = SA_DEF_DEPTH,
  parameter int unsigned DW      = SA_DEF_DATA_W,
  localparam int unsigned QW     = $clog2(NQ),
  localparam int unsigned NREQ   = NPORT * NCLIENT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NREQ-1:0]    req_valid_i,
  input  logic [NREQ-1:0]    req_produce_i,
  input  logic [NREQ*QW-1:0] req_qid_i,
  input  logic [NREQ*DW-1:0] req_data_i,
  output logic [NREQ-1:0]    req_done_o,
  output logic [NREQ-1:0]    req_stall_o,
  output logic [NREQ*DW-1:0] rsp_data_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic          pv     [NPORT];
  logic          ppush  [NPORT];
  logic [QW-1:0] pqid   [NPORT];
  logic [DW-1:0] pdata  [NPORT];
  logic          pacc   [NPORT];
  logic [DW-1:0] prdata [NPORT];

  for (genvar gp = 0; gp < NPORT; gp++) begin : g_port
    logic [NCLIENT-1:0] creq;
    logic [NCLIENT-1:0] cgnt;

    assign creq = req_valid_i[gp*NCLIENT +: NCLIENT] & {NCLIENT{rst_n}};

    sa_port_arb #(.N(NCLIENT)) u_arb (
      .clk_i   (clk_i),
      .rst_ni  (rst_n),
      .req_i   (creq),
      .grant_o (cgnt)
    );

    always_comb begin
      pv[gp]    = |creq;
      ppush[gp] = 1'b0;
      pqid[gp]  = '0;
      pdata[gp] = '0;
      for (int c = 0; c < NCLIENT; c++) begin
        if (cgnt[c]) begin
          ppush[gp] = req_produce_i[gp*NCLIENT + c];
          pqid[gp]  = req_qid_i[(gp*NCLIENT + c)*QW +: QW];
          pdata[gp] = req_data_i[(gp*NCLIENT + c)*DW +: DW];
        end
      end
    end

    for (genvar gc = 0; gc < NCLIENT; gc++) begin : g_client
      assign req_done_o[gp*NCLIENT + gc]  = cgnt[gc] & pacc[gp];
      assign req_stall_o[gp*NCLIENT + gc] = creq[gc] & ~(cgnt[gc] & pacc[gp]);
      assign rsp_data_o[(gp*NCLIENT + gc)*DW +: DW] = prdata[gp];
    end
  end

  sa_queue_bank #(
    .NPORT (NPORT),
    .NQ    (NQ),
    .DEPTH (DEPTH),
    .DW    (DW),
    .QW    (QW)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .pv_i     (pv),
    .ppush_i  (ppush),
    .pqid_i   (pqid),
    .pdata_i  (pdata),
    .pacc_o   (pacc),
    .prdata_o (prdata)
  );
endmodule

// File: tb/sa_sync_array_bench.sv
`timescale 1ns/1ps
module sa_sync_array_bench;
  localparam int NP = 4;
  localparam int NC = 2;
  localparam int NR = NP * NC;
  localparam int DEPTH = 32;

  logic              clk;
  logic              rst_n;
  logic [NR-1:0]     vld;
  logic [NR-1:0]     prd;
  logic [NR*4-1:0]   qidv;
  logic [NR*64-1:0]  datv;
  logic [NR-1:0]     done;
  logic [NR-1:0]     stall;
  logic [NR*64-1:0]  rdat;

  int    checks = 0;
  int    errors = 0;
  string tag = "R10";
  longint unsigned seq = 64'h1000;

  // behavioural model: per-queue ring contents
  longint unsigned md [16][DEPTH];
  int mh [16];
  int mc [16];

  sa_sync_array u_sa_sync_array (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .req_valid_i   (vld),
    .req_produce_i (prd),
    .req_qid_i     (qidv),
    .req_data_i    (datv),
    .req_done_o    (done),
    .req_stall_o   (stall),
    .rsp_data_o    (rdat)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic clear_reqs();
    vld = '0; prd = '0; qidv = '0; datv = '0;
  endtask

  task automatic put(int i, bit produce, int q);
    vld[i] = 1'b1;
    prd[i] = produce;
    qidv[i*4 +: 4] = 4'(q);
    seq = seq * 64'd6364136223846793005 + 64'd1442695040888963407;
    datv[i*64 +: 64] = seq;
  endtask

  task automatic chk(bit ok, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // compare outputs against the model, then commit the model state
  task automatic eval_cycle();
    int win [NP];
    bit expd [NR];
    longint unsigned expr [NR];
    for (int i = 0; i < NR; i++) begin expd[i] = 0; expr[i] = 0; end
    for (int p = 0; p < NP; p++) begin
      win[p] = -1;
      for (int c = NC - 1; c >= 0; c--) if (vld[p*NC + c]) win[p] = c;
    end
    for (int p = 0; p < NP; p++) begin
      if (win[p] >= 0) begin
        int i = p*NC + win[p];
        int q = int'(qidv[i*4 +: 4]);
        bit shadow = 0;
        for (int k = 0; k < p; k++) begin
          if (win[k] >= 0) begin
            int j = k*NC + win[k];
            if (prd[j] == prd[i] && qidv[j*4 +: 4] == qidv[i*4 +: 4]) shadow = 1;
          end
        end
        if (!shadow) begin
          if (prd[i]) expd[i] = (mc[q] < DEPTH);
          else begin
            expd[i] = (mc[q] > 0);
            expr[i] = md[q][mh[q]];
          end
        end
      end
    end
    for (int i = 0; i < NR; i++) begin
      chk(done[i] == expd[i], $sformatf("done[%0d]", i), 64'(done[i]), 64'(expd[i]));
      chk(stall[i] == (vld[i] && !expd[i]), $sformatf("stall[%0d]", i),
          64'(stall[i]), 64'(vld[i] && !expd[i]));
      if (expd[i] && !prd[i])
        chk(rdat[i*64 +: 64] == expr[i], $sformatf("rsp_data[%0d]", i),
            rdat[i*64 +: 64], expr[i]);
    end
    for (int i = 0; i < NR; i++) begin
      if (expd[i] && !prd[i]) begin
        int q = int'(qidv[i*4 +: 4]);
        mh[q] = (mh[q] + 1) % DEPTH;
        mc[q]--;
      end
    end
    for (int i = 0; i < NR; i++) begin
      if (expd[i] && prd[i]) begin
        int q = int'(qidv[i*4 +: 4]);
        md[q][(mh[q] + mc[q]) % DEPTH] = datv[i*64 +: 64];
        mc[q]++;
      end
    end
  endtask

  task automatic step();
    #1;
    eval_cycle();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int q = 0; q < 16; q++) begin mh[q] = 0; mc[q] = 0; end
    clear_reqs();
    rst_n = 1'b0;
    // R10: requests during reset raise neither done nor stall
    for (int i = 0; i < NR; i++) put(i, i % 2, i);
    repeat (3) begin
      @(negedge clk); #1;
      chk(done == '0, "R10 done during reset", 64'(done), 0);
      chk(stall == '0, "R10 stall during reset", 64'(stall), 0);
    end
    clear_reqs();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 / R5: queues start empty, consumes stall
    tag = "R10";
    for (int p = 0; p < NP; p++) put(p*NC, 0, p);
    step();
    clear_reqs();

    // R1, R2, R6: interleaved traffic on two queues, drained in order
    tag = "R1";
    for (int n = 0; n < 6; n++) begin
      clear_reqs(); put(0, 1, 3); put(2, 1, 5); step();
    end
    tag = "R2";
    for (int n = 0; n < 3; n++) begin
      clear_reqs(); put(1, 0, 3); step();
    end
    tag = "R6";
    for (int n = 0; n < 7; n++) begin
      clear_reqs(); put(4, 0, 5); put(6, 0, 3); step();
    end

    // R3, R4: fill queue 7, hold the extra produce, free a slot from another port
    tag = "R3";
    for (int n = 0; n < DEPTH + 1; n++) begin
      clear_reqs(); put(4, 1, 7); step();
    end
    tag = "R4";
    clear_reqs(); put(4, 1, 7);
    step(); step();
    put(6, 0, 7); step();
    vld[6] = 1'b0; step();
    step();
    clear_reqs();
    for (int n = 0; n < DEPTH + 1; n++) begin
      clear_reqs(); put(6, 0, 7); step();
    end

    // R5: consume on empty queue alongside the produce that fills it
    tag = "R5";
    clear_reqs(); put(0, 1, 9); put(2, 0, 9); step();
    vld[0] = 1'b0; step();
    step();

    // R9: simultaneous produce and consume keep occupancy
    tag = "R9";
    clear_reqs(); put(0, 1, 9); step();
    clear_reqs(); put(0, 1, 9); step();
    for (int n = 0; n < 5; n++) begin
      clear_reqs(); put(2, 1, 9); put(4, 0, 9); step();
    end
    for (int n = 0; n < 4; n++) begin
      clear_reqs(); put(4, 0, 9); step();
    end

    // R7: two clients on one port
    tag = "R7";
    clear_reqs(); put(0, 1, 10); put(1, 1, 11); step();
    clear_reqs(); put(3, 1, 11); put(2, 0, 10); step();
    // R8: two ports, same queue, same kind
    tag = "R8";
    clear_reqs(); put(0, 1, 4); put(2, 1, 4); put(5, 1, 4); step();
    clear_reqs(); put(0, 0, 4); put(2, 0, 4); put(4, 0, 4); step();
    // R11: all ports busy on different queues
    tag = "R11";
    clear_reqs(); put(0, 1, 12); put(2, 1, 13); put(4, 1, 14); put(6, 1, 15); step();
    clear_reqs(); put(1, 0, 12); put(3, 0, 13); put(5, 0, 14); put(7, 0, 15); step();

    // random traffic over four queues, hitting full and empty often
    tag = "R11";
    for (int n = 0; n < 4000; n++) begin
      int bias = ((n / 300) % 2 == 0) ? 70 : 30;
      clear_reqs();
      for (int i = 0; i < NR; i++)
        if (($urandom % 100) < 60)
          put(i, ($urandom % 100) < bias, $urandom % 4);
      step();
    end

    clear_reqs();
    step();
    finish_run();
  end
endmodule